// File: doc/BRIEF.md
# Overwriting Synchronous FIFO Queue

This block is a single-clock first-in first-out queue. It holds a small ring of data words, four bytes by default. Depth and word width are parameters. Entries leave in the order they arrived. A head index points at the oldest entry and a tail index points at the next free slot. Both indices wrap to zero after the last slot. An occupancy counter, one bit wider than the indices, tells a full ring apart from an empty one.

The queue never refuses a write. When a write arrives while every slot is taken, the oldest entry is dropped and the new word is stored, so the queue always keeps the most recent data. Reads return the oldest entry on a registered output. A chip-select input gates both kinds of request. Reset is synchronous and active high.

Top module: `evict_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the head, the tail and the occupancy are cleared and `dataOut` is cleared to 0. After the reset, `isEmpty` is 1 and `isFull` is 0.
- R2: Entries are read back in the order they were written. `dataOut` is registered: it takes the oldest entry on the rising edge that samples an accepted read, and keeps that value until the next accepted read.
- R3: `isEmpty` is 1 exactly when the queue holds no entries.
- R4: `isFull` is 1 exactly when the queue holds `DEPTH` entries.
- R5: A write without a read while the queue is full is accepted. The oldest entry is discarded and the new word is stored. The queue stays full, and later reads return the newest `DEPTH` words in write order.
- R6: While `chipSel` is 0, `readEn` and `writeEn` are ignored. Occupancy, flags, contents and `dataOut` do not change.
- R7: A read without a write while the queue is empty has no effect. `dataOut`, the flags and the contents keep their values.
- R8: A read and a write in the same cycle on a non-empty queue are both performed, including when the queue is full. `dataOut` takes the oldest entry, the new word is appended, and the occupancy does not change.
- R9: A read and a write in the same cycle on an empty queue perform only the write. `dataOut` keeps its value and the queue then holds one entry.
- R10: The head and tail indices wrap past the last slot. FIFO order holds across any number of passes around the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| chipSel | input | 1 | Enables read and write requests when high |
| readEn | input | 1 | Request to pop the oldest entry |
| writeEn | input | 1 | Request to push `dataIn` |
| dataIn | input | WIDTH | Word to store |
| dataOut | output | WIDTH | Registered word from the most recent accepted read |
| isEmpty | output | 1 | High when no entries are held |
| isFull | output | 1 | High when all `DEPTH` slots are held |

## Verification
Two functions can fall in the same cycle: a pop and a push. On a full queue, a push can also coincide with the eviction of the oldest entry. The bench provokes the combined pop and push on an empty queue, on a partly filled queue and on a full queue. In each case it checks that the occupancy stays as required and that the popped word is the oldest one. It also drives pushes alone into a full queue, then drains the queue to show that exactly the oldest words were lost. A queue model inside the bench, built from the requirements, supplies the expected word and flags after every clock.

// File: rtl/evict_fifo_pkg.sv
package evict_fifo_pkg;

  // Strobes sent from the control unit to the storage datapath
  typedef struct packed {
    logic wrStb;  // store dataIn at the tail slot
    logic rdStb;  // load the head slot into the output register
  } fifoStrobes_t;

endpackage

// File: rtl/evict_fifo_ctrl.sv
module evict_fifo_ctrl
  import evict_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chipSel,
  input  logic             readEn,
  input  logic             writeEn,
  output fifoStrobes_t     stb,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             isEmpty,
  output logic             isFull
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] cntQ;
  logic wantWr, wantRd, evict;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] v);
    return (v == LAST_IDX) ? '0 : v + 1'b1;
  endfunction

  assign isEmpty = (cntQ == '0);
  assign isFull  = (cntQ == FULL_CNT);

  // A read on an empty queue is dropped; a write is never refused
  assign wantWr = chipSel & writeEn;
  assign wantRd = chipSel & readEn & ~isEmpty;
  assign evict  = wantWr & ~wantRd & isFull;

  assign stb.wrStb = wantWr;
  assign stb.rdStb = wantRd;
  assign headIdx   = headQ;
  assign tailIdx   = tailQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
    end else begin
      if (wantWr) tailQ <= bump(tailQ);
      if (wantRd || evict) headQ <= bump(headQ);
      unique case ({wantWr, wantRd})
        2'b10:   if (!isFull) cntQ <= cntQ + 1'b1;
        2'b01:   cntQ <= cntQ - 1'b1;
        default: cntQ <= cntQ;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cntQ <= FULL_CNT);

  // R5
  evict_stays_full_chk: assert property (@(posedge clk) disable iff (rst)
    (chipSel && writeEn && !readEn && isFull) |=> isFull);

  // R6
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !chipSel |=> ($stable(cntQ) && $stable(headQ) && $stable(tailQ)));

  // R7
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chipSel && readEn && !writeEn && isEmpty) |=> (isEmpty && $stable(headQ)));

  // R8
  pair_count_chk: assert property (@(posedge clk) disable iff (rst)
    (chipSel && readEn && writeEn && !isEmpty) |=> $stable(cntQ));

endmodule

// File: rtl/evict_fifo_dp.sv
module evict_fifo_dp
  import evict_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobes_t     stb,
  input  logic [IDX_W-1:0] headIdx,
  input  logic [IDX_W-1:0] tailIdx,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] slotMem [DEPTH];
  logic [WIDTH-1:0] outQ;

  // Storage carries no reset; validity is tracked by the control unit
  always_ff @(posedge clk) begin
    if (stb.wrStb) slotMem[tailIdx] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (rst) outQ <= '0;
    else if (stb.rdStb) outQ <= slotMem[headIdx];
  end

  assign dataOut = outQ;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.rdStb |=> $stable(dataOut));

endmodule

// File: rtl/evict_fifo.sv
module evict_fifo
  import evict_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chipSel,
  input  logic             readEn,
  input  logic             writeEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             isEmpty,
  output logic             isFull
);

  fifoStrobes_t     stb;
  logic [IDX_W-1:0] headIdx, tailIdx;

  evict_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .chipSel (chipSel),
    .readEn  (readEn),
    .writeEn (writeEn),
    .stb     (stb),
    .headIdx (headIdx),
    .tailIdx (tailIdx),
    .isEmpty (isEmpty),
    .isFull  (isFull)
  );

  evict_fifo_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .headIdx (headIdx),
    .tailIdx (tailIdx),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/evict_fifo_tb_top.sv
`timescale 1ns/1ps
module evict_fifo_tb_top;

  localparam int DEPTH = 4;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chipSel = 1'b0, readEn = 1'b0, writeEn = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic isEmpty, isFull;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [WIDTH-1:0] model[$];
  logic [WIDTH-1:0] expOut = '0;

  always #2 clk = ~clk;  // 250 MHz

  evict_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .chipSel(chipSel), .readEn(readEn),
    .writeEn(writeEn), .dataIn(dataIn), .dataOut(dataOut),
    .isEmpty(isEmpty), .isFull(isFull)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, sample 1 ns after the rising edge,
  // update the requirement model and compare outputs
  task automatic step(input string tag, input logic c, input logic r,
                      input logic w, input logic [WIDTH-1:0] d);
    bit popped;
    @(negedge clk);
    chipSel = c; readEn = r; writeEn = w; dataIn = d;
    @(posedge clk);
    #1;
    popped = 0;
    if (c) begin
      if (r && model.size() > 0) begin
        expOut = model.pop_front();
        popped = 1;
      end
      if (w) begin
        if (!popped && model.size() == DEPTH) void'(model.pop_front());
        model.push_back(d);
      end
    end
    check({tag, " dataOut"}, 32'(dataOut), 32'(expOut));
    check("R3 isEmpty", 32'(isEmpty), 32'(model.size() == 0));
    check("R4 isFull", 32'(isFull), 32'(model.size() == DEPTH));
  endtask

  task automatic idle();
    step("R6 idle", 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic drain(input string tag);
    while (model.size() > 0) step(tag, 1'b1, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 isEmpty", 32'(isEmpty), 32'd1);
    check("R1 isFull", 32'(isFull), 32'd0);
    check("R1 dataOut", 32'(dataOut), 32'd0);
  endtask

  task automatic testFillDrain();
    for (int i = 0; i < DEPTH; i++) begin
      step("R2 fill", 1'b1, 1'b0, 1'b1, 8'h10 + 8'(i));
      check("R4 full after last fill", 32'(isFull), 32'(i == DEPTH - 1));
    end
    for (int i = 0; i < DEPTH; i++) begin
      step("R2 drain", 1'b1, 1'b1, 1'b0, 8'h00);
      check("R2 order", 32'(dataOut), 32'h10 + 32'(i));
    end
    check("R3 empty after drain", 32'(isEmpty), 32'd1);
  endtask

  task automatic testOverwrite();
    for (int i = 0; i < DEPTH + 2; i++) step("R5 write", 1'b1, 1'b0, 1'b1, 8'hA0 + 8'(i));
    check("R5 still full", 32'(isFull), 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      step("R5 drain", 1'b1, 1'b1, 1'b0, 8'h00);
      check("R5 newest kept", 32'(dataOut), 32'hA2 + 32'(i));
    end
  endtask

  task automatic testDeselect();
    step("R6 write ignored", 1'b0, 1'b0, 1'b1, 8'h55);
    check("R6 empty kept", 32'(isEmpty), 32'd1);
    step("R6 load", 1'b1, 1'b0, 1'b1, 8'h66);
    step("R6 read ignored", 1'b0, 1'b1, 1'b1, 8'h77);
    check("R6 dataOut kept", 32'(dataOut), 32'hA5);
    step("R6 read back", 1'b1, 1'b1, 1'b0, 8'h00);
    check("R6 content kept", 32'(dataOut), 32'h66);
  endtask

  task automatic testEmptyRead();
    step("R7 empty read", 1'b1, 1'b1, 1'b0, 8'h00);
    check("R7 dataOut kept", 32'(dataOut), 32'h66);
    check("R7 still empty", 32'(isEmpty), 32'd1);
  endtask

  task automatic testPairPartial();
    step("R8 load", 1'b1, 1'b0, 1'b1, 8'h31);
    step("R8 load", 1'b1, 1'b0, 1'b1, 8'h32);
    step("R8 pair", 1'b1, 1'b1, 1'b1, 8'h33);
    check("R8 oldest out", 32'(dataOut), 32'h31);
    check("R8 not empty", 32'(isEmpty), 32'd0);
    drain("R8 drain");
    check("R8 last word", 32'(dataOut), 32'h33);
  endtask

  task automatic testPairEmpty();
    step("R9 pair on empty", 1'b1, 1'b1, 1'b1, 8'h44);
    check("R9 dataOut kept", 32'(dataOut), 32'h33);
    check("R9 one entry", 32'(isEmpty), 32'd0);
    step("R9 read back", 1'b1, 1'b1, 1'b0, 8'h00);
    check("R9 stored word", 32'(dataOut), 32'h44);
  endtask

  task automatic testPairFull();
    for (int i = 0; i < DEPTH; i++) step("R8 fill", 1'b1, 1'b0, 1'b1, 8'hC0 + 8'(i));
    step("R8 pair on full", 1'b1, 1'b1, 1'b1, 8'hCF);
    check("R8 full pair out", 32'(dataOut), 32'hC0);
    check("R8 full kept", 32'(isFull), 32'd1);
    drain("R8 full drain");
    check("R8 appended last", 32'(dataOut), 32'hCF);
  endtask

  task automatic testWrap();
    for (int i = 0; i < 5 * DEPTH; i++) begin
      step("R10 push", 1'b1, 1'b0, 1'b1, 8'(i * 7 + 1));
      if (i % 3 == 2) step("R10 pop", 1'b1, 1'b1, 1'b0, 8'h00);
    end
    drain("R10 drain");
    check("R10 final empty", 32'(isEmpty), 32'd1);
  endtask

  initial begin
    testReset();
    testFillDrain();
    testOverwrite();
    testDeselect();
    testEmptyRead();
    testPairPartial();
    testPairEmpty();
    testPairFull();
    testWrap();
    idle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule